// File: doc/BRIEF.md
# YUV to RGB Color Converter

This block converts a stream of 8-bit luma and chroma samples into 8-bit red, green and blue values, one pixel per clock, through a fixed three-stage pipeline. Each channel output is a weighted sum of the luma and the two chroma samples. The weights come from a programmable set of seven fixed-point coefficients and one signed luma offset. Each is written into its own 16-bit register word, right-justified. The upper bits of each word beyond the field width are don't-care.

Coefficients are written through a simple write port into a shadow bank. The shadow bank is copied into the active bank on a frame-start pulse, so a frame is always converted with one consistent set. There is no back-pressure. A valid flag travels with each pixel, and a result appears a fixed number of cycles after its input.

Top module: `yuv2rgb_csc`

## Requirements
- R1: Red equals clip(ky·L + kur·Cb + kvr·Cr). Green uses kug and kvg and blue uses kub and kvb, with the same luma term L. Here Cb = U−128 and Cr = V−128.
- R2: The luma offset is register 0, bits [7:0], taken as a signed two's-complement integer. Bits [15:8] are ignored.
- R3: The luma gain ky is register 1, bits [9:0], unsigned, with 8 fraction bits. Bits [15:10] are ignored.
- R4: Registers 2, 3, 6 and 7 (kur, kvr, kub, kvb) are signed 11-bit values in bits [10:0], with the sign at bit 10. Registers 4 and 5 (kug, kvg) are signed 10-bit values in bits [9:0], with the sign at bit 9. All of them have 8 fraction bits, and the bits above each field are ignored.
- R5: L is Y plus the luma offset, clamped to 0..255 before it is multiplied by ky.
- R6: U and V are made signed by subtracting 128 before they are multiplied.
- R7: Each channel sum has 128 added, is arithmetically shifted right by 8, and is then clamped to 0..255. Negative results give 0.
- R8: A register write changes only the shadow bank. Conversion results do not change until a frame-start pulse.
- R9: A frame-start pulse copies the shadow bank into the active bank. A write in the same cycle is included in the copy. A pixel accepted in the same cycle as the pulse uses the new set, and a pixel accepted one cycle earlier uses the old set.
- R10: An input pixel with in_valid high, sampled at clock edge k, appears with out_valid high after edge k+2, which is three edges counting edge k. Reset clears all valid flags. Reset loads ky = 0x100 and every other register with 0, so that R = G = B = Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Coefficient register write strobe |
| cfg_addr | input | 3 | Register index: 0 offset, 1 ky, 2 kur, 3 kvr, 4 kug, 5 kvg, 6 kub, 7 kvb |
| cfg_wdata | input | 16 | Register write data |
| frame_start | input | 1 | Frame-boundary pulse that loads the active bank |
| in_valid | input | 1 | Input pixel valid |
| in_y | input | 8 | Luma sample |
| in_u | input | 8 | Blue-difference chroma sample |
| in_v | input | 8 | Red-difference chroma sample |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |

## Verification
A register write and a frame-start pulse can land in the same cycle, and a pixel can be accepted alongside them. The bench drives all three in one cycle. It changes a coefficient so that the old set and the new set give clearly different pixels. It then compares the pixel against a model that applies the write before the bank copy. A pixel sent one cycle before the pulse must still show the old coefficients, which confirms on which side of the boundary each pixel falls.

// File: rtl/yuv2rgb_csc.sv
module yuv2rgb_csc #(
  parameter int PIX_W  = 8,
  parameter int WORD_W = 16,
  parameter int FRAC_W = 8,
  parameter int NREG   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(NREG)-1:0]   cfg_addr,
  input  logic [WORD_W-1:0]         cfg_wdata,
  input  logic                      frame_start,
  input  logic                      in_valid,
  input  logic [PIX_W-1:0]          in_y,
  input  logic [PIX_W-1:0]          in_u,
  input  logic [PIX_W-1:0]          in_v,
  output logic                      out_valid,
  output logic [PIX_W-1:0]          out_r,
  output logic [PIX_W-1:0]          out_g,
  output logic [PIX_W-1:0]          out_b
);
  localparam int AW    = $clog2(NREG);
  localparam int ACC_W = 2 * PIX_W + 6;
  localparam int PMAX  = (1 << PIX_W) - 1;
  localparam int BIAS  = 1 << (PIX_W - 1);
  localparam logic [WORD_W-1:0] UNITY = WORD_W'(1 << FRAC_W);

  logic [WORD_W-1:0] sh_q [NREG];
  logic [WORD_W-1:0] sh_d [NREG];
  logic [WORD_W-1:0] act_q[NREG];

  always_comb
    for (int i = 0; i < NREG; i++)
      sh_d[i] = (cfg_we && cfg_addr == AW'(i)) ? cfg_wdata : sh_q[i];

  always_ff @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        sh_q[i]  <= (i == 1) ? UNITY : '0;
        act_q[i] <= (i == 1) ? UNITY : '0;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        sh_q[i] <= sh_d[i];
        if (frame_start) act_q[i] <= sh_d[i];
      end
    end

  function automatic logic signed [ACC_W-1:0] wide(input logic signed [10:0] x);
    return ACC_W'(x);
  endfunction

  function automatic logic [PIX_W-1:0] clip(input logic signed [ACC_W-1:0] x);
    if (x < 0) return '0;
    if (x > PMAX) return PIX_W'(PMAX);
    return x[PIX_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] k_off, k_y, k_ur, k_vr, k_ug, k_vg, k_ub, k_vb;
  assign k_off = wide({{3{act_q[0][7]}}, act_q[0][7:0]});
  assign k_y   = wide({1'b0, act_q[1][9:0]});
  assign k_ur  = wide(act_q[2][10:0]);
  assign k_vr  = wide(act_q[3][10:0]);
  assign k_ug  = wide({act_q[4][9], act_q[4][9:0]});
  assign k_vg  = wide({act_q[5][9], act_q[5][9:0]});
  assign k_ub  = wide(act_q[6][10:0]);
  assign k_vb  = wide(act_q[7][10:0]);

  logic             s1_v;
  logic [PIX_W-1:0] s1_y, s1_u, s1_v_c;
  always_ff @(posedge clk)
    if (!rst_n) begin
      s1_v <= 1'b0;
      s1_y <= '0; s1_u <= '0; s1_v_c <= '0;
    end else begin
      s1_v <= in_valid;
      s1_y <= in_y; s1_u <= in_u; s1_v_c <= in_v;
    end

  logic signed [ACC_W-1:0] cb, cr, luma, lterm;
  assign cb    = ACC_W'(s1_u)   - ACC_W'(BIAS);
  assign cr    = ACC_W'(s1_v_c) - ACC_W'(BIAS);
  assign luma  = ACC_W'(clip(ACC_W'(s1_y) + k_off));
  assign lterm = luma * k_y;

  logic                    s2_v;
  logic signed [ACC_W-1:0] s2_r, s2_g, s2_b;
  always_ff @(posedge clk)
    if (!rst_n) begin
      s2_v <= 1'b0;
      s2_r <= '0; s2_g <= '0; s2_b <= '0;
    end else begin
      s2_v <= s1_v;
      s2_r <= lterm + cb * k_ur + cr * k_vr;
      s2_g <= lterm + cb * k_ug + cr * k_vg;
      s2_b <= lterm + cb * k_ub + cr * k_vb;
    end

  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1 << (FRAC_W - 1));
  always_ff @(posedge clk)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_r <= '0; out_g <= '0; out_b <= '0;
    end else begin
      out_valid <= s2_v;
      out_r <= clip((s2_r + HALF) >>> FRAC_W);
      out_g <= clip((s2_g + HALF) >>> FRAC_W);
      out_b <= clip((s2_b + HALF) >>> FRAC_W);
    end

  logic [1:0] age;
  always_ff @(posedge clk)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R10

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    AST_SHADOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == AW'(g)) |=> (sh_q[g] == $past(cfg_wdata))); // R8
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(act_q[g])); // R8
    AST_ACTIVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !cfg_we) |=> (act_q[g] == $past(sh_q[g]))); // R9
  end
endmodule

// File: tb/yuv2rgb_csc_test.sv
`timescale 1ns/1ps
module yuv2rgb_csc_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic frame_start = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_y = '0, in_u = '0, in_v = '0;
  logic out_valid;
  logic [7:0] out_r, out_g, out_b;

  always #10 clk = ~clk;

  yuv2rgb_csc uut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start), .in_valid(in_valid),
    .in_y(in_y), .in_u(in_u), .in_v(in_v), .out_valid(out_valid),
    .out_r(out_r), .out_g(out_g), .out_b(out_b));

  int checks = 0, fails = 0, ncyc = 0;
  bit done = 0;
  logic [15:0] shm[8], acm[8];
  logic [23:0] exp_q[$];
  int stamp_q[$];
  string tag_q[$];

  function automatic int dec(int idx, logic [15:0] raw);
    case (idx)
      0: return raw[7] ? int'(raw[7:0]) - 256 : int'(raw[7:0]);
      1: return int'(raw[9:0]);
      4, 5: return raw[9] ? int'(raw[9:0]) - 1024 : int'(raw[9:0]);
      default: return raw[10] ? int'(raw[10:0]) - 2048 : int'(raw[10:0]);
    endcase
  endfunction

  function automatic int chan(int ys, int u, int v, int ku, int kv, int ky);
    int s;
    s = ys * ky + (u - 128) * ku + (v - 128) * kv;
    s = (s + 128) >>> 8;
    return s < 0 ? 0 : (s > 255 ? 255 : s);
  endfunction

  task automatic step(input bit we, input logic [2:0] a, input logic [15:0] d,
                      input bit fs, input bit vld, input logic [7:0] y, u, v,
                      input string tag);
    int ys, r, g, b;
    @(negedge clk); #1;
    cfg_we = we; cfg_addr = a; cfg_wdata = d; frame_start = fs;
    in_valid = vld; in_y = y; in_u = u; in_v = v;
    if (we) shm[a] = d;
    if (fs) for (int i = 0; i < 8; i++) acm[i] = shm[i];
    if (vld) begin
      ys = int'(y) + dec(0, acm[0]);
      ys = ys < 0 ? 0 : (ys > 255 ? 255 : ys);
      r = chan(ys, u, v, dec(2, acm[2]), dec(3, acm[3]), dec(1, acm[1]));
      g = chan(ys, u, v, dec(4, acm[4]), dec(5, acm[5]), dec(1, acm[1]));
      b = chan(ys, u, v, dec(6, acm[6]), dec(7, acm[7]), dec(1, acm[1]));
      exp_q.push_back({r[7:0], g[7:0], b[7:0]});
      stamp_q.push_back(ncyc + 3);
      tag_q.push_back(tag);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input bit fs);
    step(1, a, d, fs, 0, 0, 0, 0, "");
  endtask

  task automatic px(input logic [7:0] y, u, v, input string tag);
    step(0, 0, 0, 0, 1, y, u, v, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  always @(negedge clk) begin
    ncyc++;
    if (rst_n && out_valid) begin
      logic [23:0] e; int st; string t;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10: unexpected output %h expected none", {out_r, out_g, out_b});
      end else begin
        e = exp_q.pop_front(); st = stamp_q.pop_front(); t = tag_q.pop_front();
        if ({out_r, out_g, out_b} !== e || ncyc != st) begin
          fails++;
          $display("FAIL %s: got %h at cycle %0d expected %h at cycle %0d",
                   t, {out_r, out_g, out_b}, ncyc, e, st);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin shm[i] = (i == 1) ? 16'h0100 : 16'h0; acm[i] = shm[i]; end
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    checks++;
    if (out_valid !== 1'b0 || {out_r, out_g, out_b} !== 24'h0) begin
      fails++;
      $display("FAIL R10: reset outputs got %b/%h expected 0/000000", out_valid, {out_r, out_g, out_b});
    end
    rst_n = 1'b1;
    // R10: reset defaults give R=G=B=Y, with gaps in valid
    px(8'd0, 8'd3, 8'd250, "R10");
    px(8'd77, 8'd200, 8'd10, "R10");
    idle(2);
    px(8'd255, 8'd128, 8'd128, "R10");
    // R8: shadow writes have no effect before frame start
    wr(0, 16'h00F0, 0); wr(1, 16'h012A, 0); wr(2, 16'h0000, 0); wr(3, 16'h0199, 0);
    wr(4, 16'h039C, 0); wr(5, 16'h0330, 0); wr(6, 16'h0205, 0); wr(7, 16'h0000, 0);
    px(8'd120, 8'd30, 8'd220, "R8");
    // R1 R6: new set after frame start, several patterns
    step(0, 0, 0, 1, 0, 0, 0, 0, "");
    px(8'd16, 8'd128, 8'd128, "R6");
    px(8'd235, 8'd128, 8'd128, "R1");
    px(8'd81, 8'd90, 8'd240, "R1");
    px(8'd145, 8'd54, 8'd34, "R1");
    px(8'd41, 8'd240, 8'd110, "R6");
    px(8'd0, 8'd0, 8'd255, "R7");
    // R2 R3 R5: offset +20 with junk upper bits, gain 0.5 with junk upper bits
    wr(0, 16'hFF14, 0); wr(1, 16'hFC80, 0);
    wr(2, 16'h0000, 0); wr(3, 16'h0000, 0); wr(4, 16'h0000, 0);
    wr(5, 16'h0000, 0); wr(6, 16'h0000, 0); wr(7, 16'h0000, 1);
    px(8'd100, 8'd128, 8'd128, "R2");
    px(8'd250, 8'd128, 8'd128, "R5");
    px(8'd240, 8'd128, 8'd128, "R3");
    // R7: half-up rounding at gain 0.5 with offset 0
    wr(0, 16'h0000, 1);
    px(8'd1, 8'd128, 8'd128, "R7");
    px(8'd3, 8'd128, 8'd128, "R7");
    // R4: sign bits at 10 and 9 with junk above
    wr(1, 16'h0100, 0); wr(2, 16'hFF00, 0); wr(4, 16'hFE00, 0); wr(6, 16'h0480, 1);
    px(8'd200, 8'd160, 8'd128, "R4");
    px(8'd60, 8'd100, 8'd128, "R4");
    // R9: pixel before pulse keeps old set; write + pulse + pixel in one cycle
    px(8'd90, 8'd150, 8'd128, "R9");
    step(1, 3'd1, 16'h0200, 1, 1, 8'd90, 8'd150, 8'd128, "R9");
    px(8'd90, 8'd150, 8'd128, "R9");
    idle(6);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10: %0d outputs missing expected 0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule